// File: doc/BRIEF.md
# Prioritised Shared Interrupt Vector Generator

This block gathers the event flags of a timer's shared interrupt sources into one vector. The sources are capture/compare channels 1 to N (four by default) and the counter overflow event. Each source raises its flag through a one-cycle set strobe and has its own enable. The vector output gives a code for the enabled pending source with the highest priority. The code is even, so software can add it to a program counter and use it as a jump-table offset. When no enabled source is pending the code is zero.

A single read strobe on the vector acknowledges only the source that the vector reports in that cycle. The next pending enabled source then shows on the vector one cycle later. Capture/compare channel 0 stays out of the vector. It has its own flag, enable, acknowledge strobe and interrupt line. The shared interrupt line is high whenever the vector is non-zero.

Top module: `irqVectorUnit`

## Requirements
- R1: While reset is active, and right after it, every flag is clear, `vecOut` is 0x00, and `irqShared` and `irqCh0` are low.
- R2: `vecOut` encodes the reported source as follows: channel k (k = 1..4, which is bit k-1 of `chanSetStb`/`chanEn`) gives 2·k (0x02, 0x04, 0x06, 0x08), overflow gives 0x0E, and no enabled pending source gives 0x00.
- R3: When several enabled flags are pending, channel 1 has the highest priority, then channels 2, 3 and 4, and overflow has the lowest.
- R4: A flag whose enable is low stays pending but does not show on `vecOut`. When its enable is raised, it is reported without being set again.
- R5: A clock edge with `vecRdStb` high clears only the flag that `vecOut` reports in that cycle. From the next cycle `vecOut` reports the next pending enabled source.
- R6: If a set strobe for a source arrives in the same cycle as a read that clears that source, the flag stays set.
- R7: A read while `vecOut` is 0x00 clears nothing. This includes flags that are pending but disabled.
- R8: `irqShared` is high exactly when `vecOut` is non-zero.
- R9: Channel 0 has its own flag, set by `ch0SetStb` and cleared by `ch0AckStb`, where a set in the same cycle wins. `irqCh0` = flag AND `ch0En`. The channel 0 flag never affects `vecOut` or `irqShared`.
- R10: Flags are registered. A set strobe sampled at a clock edge becomes visible on the outputs after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanSetStb | input | NUM_CH | Flag-set strobes, bit i = channel i+1 |
| ovfSetStb | input | 1 | Overflow flag-set strobe |
| chanEn | input | NUM_CH | Enables, bit i = channel i+1 |
| ovfEn | input | 1 | Overflow enable |
| vecRdStb | input | 1 | Vector read strobe (acknowledges reported source) |
| ch0SetStb | input | 1 | Channel 0 flag-set strobe |
| ch0AckStb | input | 1 | Channel 0 flag clear strobe |
| ch0En | input | 1 | Channel 0 enable |
| vecOut | output | 8 | Current interrupt vector code |
| irqShared | output | 1 | Shared interrupt request |
| irqCh0 | output | 1 | Channel 0 interrupt request |

## Verification
The assertions check on every cycle the properties that hold locally in time. A zero vector with no visible flag, even codes, a shared request only when a flag is visible, set-wins on flags, clearing of a reported channel 1 or overflow flag, and flags left unchanged by an empty read are all checked this way. The bench's scenarios are needed for the rest. They show the full priority ordering as a chain of reads steps through every source. They show disabled flags surviving reads and then appearing once enabled. They also show the exact cycle at which a new flag becomes visible, and the independence of channel 0 from the shared vector.

// File: rtl/irqVecPkg.sv
package irqVecPkg;
  localparam int unsigned VEC_W = 8;
  localparam int unsigned IDX_W = 3;

  // Strobes from the control to the flag store
  typedef struct packed {
    logic             ackValid;
    logic [IDX_W-1:0] ackIdx;
    logic             ch0Ack;
  } ackStrobes_t;
endpackage

// File: rtl/irqFlagStore.sv
module irqFlagStore
  import irqVecPkg::*;
#(
  parameter int unsigned NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] setStb,
  input  logic               ch0SetStb,
  input  ackStrobes_t        strobes,
  output logic [NUM_SRC-1:0] flagsQ,
  output logic               ch0FlagQ
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    logic clrHit;
    assign clrHit = strobes.ackValid && (strobes.ackIdx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rstN) flagsQ[i] <= 1'b0;
      else       flagsQ[i] <= setStb[i] | (flagsQ[i] & ~clrHit);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ch0FlagQ <= 1'b0;
    else       ch0FlagQ <= ch0SetStb | (ch0FlagQ & ~strobes.ch0Ack);
  end
endmodule

// File: rtl/irqVectorCtrl.sv
module irqVectorCtrl
  import irqVecPkg::*;
#(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned OVF_CODE = 14
) (
  input  logic [NUM_CH:0]    flagsQ,
  input  logic [NUM_CH:0]    srcEn,
  input  logic               vecRdStb,
  input  logic               ch0AckStb,
  output logic [VEC_W-1:0]   vecOut,
  output ackStrobes_t        strobes
);
  localparam int unsigned NUM_SRC = NUM_CH + 1;

  logic [NUM_SRC-1:0] visible;
  logic               anyHit;
  logic [IDX_W-1:0]   winIdx;

  assign visible = flagsQ & srcEn;

  // Lowest index wins: scan from the bottom of the priority list upward
  always_comb begin
    anyHit = 1'b0;
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (visible[i]) begin
        anyHit = 1'b1;
        winIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (!anyHit)                     vecOut = '0;
    else if (winIdx == IDX_W'(NUM_CH)) vecOut = VEC_W'(OVF_CODE);
    else                             vecOut = VEC_W'((32'(winIdx) + 1) * 2);
  end

  always_comb begin
    strobes.ackValid = vecRdStb && anyHit;
    strobes.ackIdx   = winIdx;
    strobes.ch0Ack   = ch0AckStb;
  end
endmodule

// File: rtl/irqVectorUnit.sv
module irqVectorUnit
  import irqVecPkg::*;
#(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned OVF_CODE = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chanSetStb,
  input  logic              ovfSetStb,
  input  logic [NUM_CH-1:0] chanEn,
  input  logic              ovfEn,
  input  logic              vecRdStb,
  input  logic              ch0SetStb,
  input  logic              ch0AckStb,
  input  logic              ch0En,
  output logic [7:0]        vecOut,
  output logic              irqShared,
  output logic              irqCh0
);
  localparam int unsigned NUM_SRC = NUM_CH + 1;

  logic [NUM_SRC-1:0] flagsQ;
  logic               ch0FlagQ;
  ackStrobes_t        strobes;
  logic [VEC_W-1:0]   vecCode;

  irqFlagStore #(.NUM_SRC(NUM_SRC)) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .setStb    ({ovfSetStb, chanSetStb}),
    .ch0SetStb (ch0SetStb),
    .strobes   (strobes),
    .flagsQ    (flagsQ),
    .ch0FlagQ  (ch0FlagQ)
  );

  irqVectorCtrl #(.NUM_CH(NUM_CH), .OVF_CODE(OVF_CODE)) u_ctrl (
    .flagsQ    (flagsQ),
    .srcEn     ({ovfEn, chanEn}),
    .vecRdStb  (vecRdStb),
    .ch0AckStb (ch0AckStb),
    .vecOut    (vecCode),
    .strobes   (strobes)
  );

  assign vecOut    = vecCode;
  assign irqShared = |vecCode;
  assign irqCh0    = ch0FlagQ & ch0En;
endmodule

// File: rtl/irqVectorChk.sv
module irqVectorChk #(
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] chanSetStb,
  input logic              ovfSetStb,
  input logic [NUM_CH-1:0] chanEn,
  input logic              ovfEn,
  input logic              vecRdStb,
  input logic              ch0SetStb,
  input logic              ch0AckStb,
  input logic [7:0]        vecOut,
  input logic              irqShared,
  input logic [NUM_CH:0]   flagsQ,
  input logic              ch0FlagQ
);
  logic [NUM_CH:0] visible;
  assign visible = flagsQ & {ovfEn, chanEn};

  // R2: nothing visible means a zero code
  a_r2_zero_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (visible == '0) |-> (vecOut == 8'h00));

  // R2: codes are always even
  a_r2_even_code: assert property (@(posedge clk) disable iff (!rstN)
    vecOut[0] == 1'b0);

  // R8: shared request only with a visible flag
  a_r8_shared_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    irqShared |-> (visible != '0));

  // R5: reading a reported channel 1 clears it
  a_r5_clear_ch1: assert property (@(posedge clk) disable iff (!rstN)
    (vecRdStb && vecOut == 8'h02 && !chanSetStb[0]) |=> !flagsQ[0]);

  // R5: reading a reported overflow clears it
  a_r5_clear_ovf: assert property (@(posedge clk) disable iff (!rstN)
    (vecRdStb && vecOut == 8'h0E && !ovfSetStb) |=> !flagsQ[NUM_CH]);

  // R6: a set strobe always leaves its flag set
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    chanSetStb[0] |=> flagsQ[0]);

  // R7: an empty read with no set strobes changes no flag
  a_r7_empty_read: assert property (@(posedge clk) disable iff (!rstN)
    (vecRdStb && vecOut == 8'h00 && chanSetStb == '0 && !ovfSetStb) |=> $stable(flagsQ));

  // R9: channel 0 set wins, acknowledge clears otherwise
  a_r9_ch0_set: assert property (@(posedge clk) disable iff (!rstN)
    ch0SetStb |=> ch0FlagQ);
  a_r9_ch0_ack: assert property (@(posedge clk) disable iff (!rstN)
    (ch0AckStb && !ch0SetStb) |=> !ch0FlagQ);
endmodule

bind irqVectorUnit irqVectorChk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .chanSetStb (chanSetStb),
  .ovfSetStb  (ovfSetStb),
  .chanEn     (chanEn),
  .ovfEn      (ovfEn),
  .vecRdStb   (vecRdStb),
  .ch0SetStb  (ch0SetStb),
  .ch0AckStb  (ch0AckStb),
  .vecOut     (vecOut),
  .irqShared  (irqShared),
  .flagsQ     (flagsQ),
  .ch0FlagQ   (ch0FlagQ)
);

// File: tb/irqVectorUnit_tb.sv
module irqVectorUnit_tb;
  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] chanSetStb;
  logic       ovfSetStb;
  logic [3:0] chanEn;
  logic       ovfEn;
  logic       vecRdStb;
  logic       ch0SetStb;
  logic       ch0AckStb;
  logic       ch0En;
  logic [7:0] vecOut;
  logic       irqShared;
  logic       irqCh0;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  irqVectorUnit u_dut (
    .clk(clk), .rstN(rstN), .chanSetStb(chanSetStb), .ovfSetStb(ovfSetStb),
    .chanEn(chanEn), .ovfEn(ovfEn), .vecRdStb(vecRdStb), .ch0SetStb(ch0SetStb),
    .ch0AckStb(ch0AckStb), .ch0En(ch0En), .vecOut(vecOut),
    .irqShared(irqShared), .irqCh0(irqCh0)
  );

  typedef struct packed {
    logic [3:0] set;
    logic       ovfSet;
    logic [3:0] en;
    logic       ovfOn;
    logic       rd;
    logic [7:0] expVec;
  } row_t;

  localparam int NROWS = 24;
  localparam row_t ROWS [NROWS] = '{
    '{4'b0100, 1'b0, 4'hF, 1'b1, 1'b0, 8'h06},  // R10 set ch3
    '{4'b0001, 1'b0, 4'hF, 1'b1, 1'b0, 8'h02},  // R3 ch1 over ch3
    '{4'b0000, 1'b0, 4'hF, 1'b1, 1'b1, 8'h06},  // R5 read ch1
    '{4'b0000, 1'b1, 4'hF, 1'b1, 1'b1, 8'h0E},  // R5 read ch3, ovf arrives
    '{4'b0000, 1'b0, 4'hF, 1'b1, 1'b1, 8'h00},  // R5 read ovf
    '{4'b0000, 1'b0, 4'hF, 1'b1, 1'b1, 8'h00},  // R7 empty read
    '{4'b1010, 1'b0, 4'h0, 1'b0, 1'b0, 8'h00},  // R4 disabled pending
    '{4'b0000, 1'b0, 4'h8, 1'b0, 1'b0, 8'h08},  // R4 enable ch4
    '{4'b0000, 1'b0, 4'hF, 1'b1, 1'b0, 8'h04},  // R4 enable all
    '{4'b0010, 1'b0, 4'hF, 1'b1, 1'b1, 8'h04},  // R6 set wins
    '{4'b0000, 1'b0, 4'hF, 1'b1, 1'b1, 8'h08},  // R5 read ch2
    '{4'b0000, 1'b0, 4'h7, 1'b1, 1'b1, 8'h00},  // R7 read, ch4 disabled
    '{4'b0000, 1'b0, 4'hF, 1'b1, 1'b0, 8'h08},  // R4 ch4 survived
    '{4'b0000, 1'b0, 4'hF, 1'b1, 1'b1, 8'h00},  // R5 read ch4
    '{4'b1111, 1'b1, 4'hF, 1'b1, 1'b0, 8'h02},  // R3 all pending
    '{4'b0000, 1'b0, 4'hF, 1'b1, 1'b1, 8'h04},  // R3 chain
    '{4'b0000, 1'b0, 4'hF, 1'b1, 1'b1, 8'h06},  // R3 chain
    '{4'b0000, 1'b0, 4'hF, 1'b1, 1'b1, 8'h08},  // R3 chain
    '{4'b0000, 1'b0, 4'hF, 1'b1, 1'b1, 8'h0E},  // R3 chain
    '{4'b0000, 1'b0, 4'hF, 1'b1, 1'b1, 8'h00},  // R3 chain end
    '{4'b0100, 1'b1, 4'h0, 1'b1, 1'b0, 8'h0E},  // R2 ovf only enabled
    '{4'b0000, 1'b0, 4'h0, 1'b1, 1'b1, 8'h00},  // R5 read ovf
    '{4'b0000, 1'b0, 4'hF, 1'b1, 1'b0, 8'h06},  // R4 ch3 revealed
    '{4'b0000, 1'b0, 4'hF, 1'b1, 1'b1, 8'h00}   // R5 read ch3
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    chanSetStb = '0; ovfSetStb = 1'b0; vecRdStb = 1'b0;
    ch0SetStb = 1'b0; ch0AckStb = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; idleInputs(); chanEn = '0; ovfEn = 1'b0; ch0En = 1'b0;
    // R1: strobes during reset are ignored
    @(negedge clk); chanSetStb = 4'hF; ch0SetStb = 1'b1; chanEn = 4'hF; ch0En = 1'b1;
    @(posedge clk); #1;
    check("R1 vec in reset", vecOut, 8'h00);
    check("R1 irqShared in reset", {7'b0, irqShared}, 8'h00);
    check("R1 irqCh0 in reset", {7'b0, irqCh0}, 8'h00);
    @(negedge clk); idleInputs(); chanEn = '0; ch0En = 1'b0;
    @(negedge clk); rstN = 1'b1; ovfEn = 1'b1; chanEn = 4'hF;
    @(posedge clk); #1;
    check("R1 vec after reset", vecOut, 8'h00);

    // Table walk
    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk);
      chanSetStb = ROWS[i].set; ovfSetStb = ROWS[i].ovfSet;
      chanEn = ROWS[i].en; ovfEn = ROWS[i].ovfOn; vecRdStb = ROWS[i].rd;
      @(posedge clk); #1;
      check($sformatf("R2/R3/R5 row %0d vec", i), vecOut, ROWS[i].expVec);
      check($sformatf("R8 row %0d irqShared", i), {7'b0, irqShared},
            {7'b0, ROWS[i].expVec != 8'h00});
    end
    @(negedge clk); idleInputs(); chanEn = 4'hF; ovfEn = 1'b1;

    // R10: a set strobe is not visible before the edge
    @(negedge clk); chanSetStb = 4'b0010;
    #1 check("R10 before edge", vecOut, 8'h00);
    @(posedge clk); #1 check("R10 after edge", vecOut, 8'h04);
    @(negedge clk); idleInputs();

    // R9: channel 0 is separate from the vector
    ch0SetStb = 1'b1; ch0En = 1'b0;
    @(posedge clk); #1;
    check("R9 ch0 disabled irq", {7'b0, irqCh0}, 8'h00);
    @(negedge clk); idleInputs(); ch0En = 1'b1;
    #1 check("R9 ch0 enabled irq", {7'b0, irqCh0}, 8'h01);
    check("R9 vec unaffected", vecOut, 8'h04);
    @(negedge clk); ch0SetStb = 1'b1; ch0AckStb = 1'b1;
    @(posedge clk); #1 check("R9 ch0 set wins", {7'b0, irqCh0}, 8'h01);
    @(negedge clk); idleInputs(); ch0AckStb = 1'b1;
    @(posedge clk); #1 check("R9 ch0 ack clears", {7'b0, irqCh0}, 8'h00);
    check("R9 ch0 ack leaves vec", vecOut, 8'h04);
    @(negedge clk); idleInputs(); vecRdStb = 1'b1;
    @(posedge clk); #1 check("R5 final read", vecOut, 8'h00);
    check("R8 final irqShared", {7'b0, irqShared}, 8'h00);

    // R1: reset clears pending flags
    @(negedge clk); idleInputs(); chanSetStb = 4'b1000; ch0SetStb = 1'b1;
    @(negedge clk); idleInputs(); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    #1 check("R1 reset clears vec", vecOut, 8'h00);
    check("R1 reset clears ch0", {7'b0, irqCh0}, 8'h00);

    finishRun();
  end
endmodule